// File: doc/BRIEF.md
# One-Hot Jackpot LED Game

A reaction game driven by a row of LEDs and a matching row of switches. While play is running, a single lit LED walks along the row in ascending order and returns to the start after the last position. A prescaler sets the walking rate: fast enough to make the game hard, but slow enough that the eye can still follow which LED is lit. Each LED has one switch of its own. A player who turns that switch on while its LED is lit wins, and from then on every LED stays lit.

The switches are asynchronous to the clock, so each one passes through a synchroniser and then an edge detector. Only a change from off to on can score a win. A switch that is already on when the light reaches its LED cannot win. After a win the display freezes with all LEDs on until reset. Reset starts a new round with LED 0 lit.

Top module: `jackpot_game`

## Requirements
- R1: After reset, `led` shows LED 0 alone lit (value 4'b0001 for four LEDs) and the game is in play.
- R2: During play, exactly one bit of `led` is set in every cycle.
- R3: During play, the lit position moves one place toward the higher bit index once every `STEP_DIV` clock cycles. The first move comes at the `STEP_DIV`-th rising edge after reset is released.
- R4: After the highest LED, the lit position wraps to LED 0.
- R5: A switch that goes from 0 to 1 is registered by two synchroniser flops, then compared against the LED lit between the second and third rising edges after the change. If the two positions match, `led` is all ones after the third rising edge.
- R6: A switch that is held at 1 has no effect when the lit position arrives at its LED. Rotation continues.
- R7: A rising switch whose LED is not lit at the compare cycle has no effect. Rotation continues.
- R8: Once all LEDs are lit, they stay lit, whatever the switches do, until reset.
- R9: Asserting reset during the jackpot display returns to play with LED 0 lit and the step timing restarted.
- R10: If several switches rise in the same cycle, the game wins when one of them belongs to the lit LED.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sw | input | NUM_LEDS | Player switches, asynchronous, bit i paired with LED i |
| led | output | NUM_LEDS | LED drive: one-hot during play, all ones after a win |

## Verification
The assertions check three things on every cycle:
- During play, `led` is one-hot.
- A prescaler tick moves the lit bit by exactly one rotate-left.
- The all-on display never drops once entered, and it can only begin one cycle after a switch rise coincided with the lit LED.

Only the bench scenarios can show the rest. These are the exact latency from a switch change to the jackpot, the rejection of a switch that was already on, the harmless rise on an unlit LED, and the restart after reset. The bench runs a cycle model of the synchroniser, prescaler and rotation against both random switch activity and directed sequences.

// File: rtl/jackpot_pkg.sv
package jackpot_pkg;

  typedef enum logic [0:0] {
    GAME_PLAY    = 1'b0,
    GAME_JACKPOT = 1'b1
  } gameState_t;

  typedef struct packed {
    logic advance;
    logic showAll;
  } gameStrobe_t;

endpackage

// File: rtl/jackpot_prescaler.sv
module jackpot_prescaler #(
  parameter int STEP_DIV = 15_625_000
) (
  input  logic clk,
  input  logic rstN,
  output logic stepTick
);
  localparam int CNT_W = (STEP_DIV > 2) ? $clog2(STEP_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_DIV - 1);

  logic [CNT_W-1:0] divCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (divCnt == LAST) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign stepTick = (divCnt == LAST);

endmodule

// File: rtl/jackpot_sw_edge.sv
module jackpot_sw_edge #(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] swIn,
  output logic [WIDTH-1:0] swRise
);
  logic [SYNC_STAGES-1:0][WIDTH-1:0] syncChain;
  logic [WIDTH-1:0]                  swPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncChain <= '0;
      swPrev    <= '0;
    end else begin
      syncChain[0] <= swIn;
      for (int s = 1; s < SYNC_STAGES; s++) begin
        syncChain[s] <= syncChain[s-1];
      end
      swPrev <= syncChain[SYNC_STAGES-1];
    end
  end

  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_rise
      assign swRise[b] = syncChain[SYNC_STAGES-1][b] & ~swPrev[b];
    end
  endgenerate

endmodule

// File: rtl/jackpot_control.sv
module jackpot_control
  import jackpot_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        stepTick,
  input  logic        litHit,
  output gameStrobe_t strobe
);
  gameState_t curState;
  gameState_t nextState;

  always_comb begin
    nextState = curState;
    unique case (curState)
      GAME_PLAY:    if (litHit) nextState = GAME_JACKPOT;
      GAME_JACKPOT: nextState = GAME_JACKPOT;
      default:      nextState = GAME_PLAY;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curState <= GAME_PLAY;
    end else begin
      curState <= nextState;
    end
  end

  always_comb begin
    strobe.advance = stepTick && (curState == GAME_PLAY);
    strobe.showAll = (curState == GAME_JACKPOT);
  end

endmodule

// File: rtl/jackpot_datapath.sv
module jackpot_datapath
  import jackpot_pkg::*;
#(
  parameter int NUM_LEDS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  gameStrobe_t         strobe,
  input  logic [NUM_LEDS-1:0] swRise,
  output logic                litHit,
  output logic [NUM_LEDS-1:0] led
);
  localparam logic [NUM_LEDS-1:0] FIRST_LED = NUM_LEDS'(1);

  logic [NUM_LEDS-1:0] litPos;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      litPos <= FIRST_LED;
    end else if (strobe.advance) begin
      litPos <= {litPos[NUM_LEDS-2:0], litPos[NUM_LEDS-1]};
    end
  end

  assign litHit = |(litPos & swRise);
  assign led    = strobe.showAll ? '1 : litPos;

endmodule

// File: rtl/jackpot_game.sv
module jackpot_game
  import jackpot_pkg::*;
#(
  parameter int NUM_LEDS    = 4,
  parameter int STEP_DIV    = 15_625_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_LEDS-1:0] sw,
  output logic [NUM_LEDS-1:0] led
);
  logic                stepTick;
  logic [NUM_LEDS-1:0] swRise;
  logic                litHit;
  gameStrobe_t         strobe;

  jackpot_prescaler #(.STEP_DIV(STEP_DIV)) i_prescaler (
    .clk(clk), .rstN(rstN), .stepTick(stepTick)
  );

  jackpot_sw_edge #(.WIDTH(NUM_LEDS), .SYNC_STAGES(SYNC_STAGES)) i_swEdge (
    .clk(clk), .rstN(rstN), .swIn(sw), .swRise(swRise)
  );

  jackpot_control i_control (
    .clk(clk), .rstN(rstN), .stepTick(stepTick), .litHit(litHit), .strobe(strobe)
  );

  jackpot_datapath #(.NUM_LEDS(NUM_LEDS)) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .swRise(swRise),
    .litHit(litHit), .led(led)
  );

endmodule

// File: rtl/jackpot_game_checker.sv
module jackpot_game_checker #(
  parameter int NUM_LEDS = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                stepTick,
  input logic [NUM_LEDS-1:0] swRise,
  input logic [NUM_LEDS-1:0] led
);
  localparam logic [NUM_LEDS-1:0] ALL_ON = '1;

  a_r2_onehot_play: assert property (@(posedge clk) disable iff (!rstN)
    (led != ALL_ON) |-> $onehot(led));

  a_r3_single_step: assert property (@(posedge clk) disable iff (!rstN)
    (stepTick && led != ALL_ON) |=>
      ((led == {$past(led[NUM_LEDS-2:0]), $past(led[NUM_LEDS-1])}) || (led == ALL_ON)));

  a_r5_win_needs_rise: assert property (@(posedge clk) disable iff (!rstN)
    (led != ALL_ON) ##1 (led == ALL_ON) |-> ($past(|(swRise & led))));

  a_r8_jackpot_holds: assert property (@(posedge clk) disable iff (!rstN)
    (led == ALL_ON) |=> (led == ALL_ON));

endmodule

bind jackpot_game jackpot_game_checker #(.NUM_LEDS(NUM_LEDS)) i_checker (
  .clk(clk), .rstN(rstN), .stepTick(stepTick), .swRise(swRise), .led(led)
);

// File: tb/test_jackpot_game.sv
module test_jackpot_game;
  localparam int N = 4;
  localparam int D = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] sw = '0;
  logic [N-1:0] led;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  int           mCnt;
  logic [N-1:0] mPos, mS1, mS2, mS3;
  bit           mWon;

  always #2 clk = ~clk;

  jackpot_game #(.NUM_LEDS(N), .STEP_DIV(D), .SYNC_STAGES(2)) i_jackpot_game (
    .clk(clk), .rstN(rstN), .sw(sw), .led(led)
  );

  function automatic logic [N-1:0] rotUp(input logic [N-1:0] v);
    return {v[N-2:0], v[N-1]};
  endfunction

  function automatic logic [N-1:0] expLed();
    return mWon ? {N{1'b1}} : mPos;
  endfunction

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: led=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    mCnt = 0; mPos = N'(1); mS1 = '0; mS2 = '0; mS3 = '0; mWon = 0;
  endtask

  task automatic modelStep(input logic [N-1:0] swNow);
    bit tick;
    logic [N-1:0] rise;
    tick = (mCnt == D - 1);
    rise = mS2 & ~mS3;
    if (!mWon && tick) mPos = rotUp(mPos);
    if (|(expLed() & rise) || mWon) mWon = 1;
    mCnt = tick ? 0 : mCnt + 1;
    mS3 = mS2; mS2 = mS1; mS1 = swNow;
  endtask

  // Model computes position before win using pre-edge state
  task automatic cycle(input logic [N-1:0] swNext, input string tag);
    logic [N-1:0] posBefore;
    bit wonBefore;
    logic [N-1:0] rise;
    sw = swNext;
    @(posedge clk);
    posBefore = mPos; wonBefore = mWon; rise = mS2 & ~mS3;
    if (!mWon && (mCnt == D - 1)) mPos = rotUp(mPos);
    if (!wonBefore && |(posBefore & rise)) mWon = 1;
    mCnt = (mCnt == D - 1) ? 0 : mCnt + 1;
    mS3 = mS2; mS2 = mS1; mS1 = swNext;
    @(negedge clk);
    check(tag, led, expLed());
  endtask

  task automatic doReset(input logic [N-1:0] swHold);
    @(negedge clk);
    rstN = 1'b0;
    sw = swHold;
    modelReset();
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    mS1 = '0; mS2 = '0; mS3 = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog: led=%b expected completion", led);
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h1d5a;
    void'($urandom(seed));

    // R1 reset state
    doReset('0);
    check("R1", led, 4'b0001);

    // R3 / R4 plain rotation with switches off
    for (int i = 0; i < 4 * D + 2; i++) begin
      cycle('0, "R3");
      if (i == D - 1)     check("R3", led, 4'b0010);
      if (i == 2 * D - 1) check("R3", led, 4'b0100);
      if (i == 4 * D - 1) check("R4", led, 4'b0001);
    end

    // R7 rise on an unlit LED, then R6 held switch when light arrives
    doReset('0);
    cycle(4'b0010, "R7");
    cycle(4'b0010, "R7");
    cycle(4'b0010, "R7");
    check("R7", led, 4'b0001);
    for (int i = 0; i < 2 * D; i++) cycle(4'b0010, "R6");
    check("R6", led, 4'b0100);

    // R5 latency of a win on LED 0
    doReset('0);
    cycle(4'b0001, "R5");
    cycle(4'b0001, "R5");
    check("R5", led, 4'b0001);
    cycle(4'b0001, "R5");
    check("R5", led, 4'b1111);

    // R8 jackpot holds under switch activity
    for (int i = 0; i < 3 * D; i++) cycle(N'($urandom_range(15)), "R8");
    check("R8", led, 4'b1111);

    // R9 reset from jackpot
    doReset('0);
    check("R9", led, 4'b0001);
    for (int i = 0; i < D; i++) cycle('0, "R9");
    check("R9", led, 4'b0010);

    // R10 several switches rising together, lit one among them
    doReset('0);
    for (int i = 0; i < D; i++) cycle('0, "R10");
    cycle(4'b1010, "R10");
    cycle(4'b1010, "R10");
    cycle(4'b1010, "R10");
    check("R10", led, 4'b1111);

    // Random play against the cycle model (R2, R3, R5, R6, R7, R8)
    for (int e = 0; e < 20; e++) begin
      logic [N-1:0] swCur;
      swCur = '0;
      doReset('0);
      for (int c = 0; c < 120; c++) begin
        if ($urandom_range(5) == 0) swCur[$urandom_range(N - 1)] ^= 1'b1;
        cycle(swCur, mWon ? "R8" : "R2");
      end
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule